// File: doc/BRIEF.md
# Glitch-Free Programmable Card Clock Divider

This block takes a fast input clock and derives a slower card clock from it. The division ratio is programmable, and the card clock keeps an exact 50% duty cycle at every ratio. Every change of ratio is held back until the current output period has ended. A stop or run request is held back in the same way. The output therefore never shows a shortened high or low phase.

A host programs the block through a small parallel port with two address bits and two data bits. The port listens only while both active-low qualifiers are asserted. Address 0 holds the ratio code. Address 1 holds the stop request and the level at which a stopped clock rests.

Ratios that would push the card clock above the allowed maximum, given the input frequency set by parameter, are refused. A pending flag shows that an accepted setting has not yet taken effect. The host waits for this flag to drop before it starts a transfer.

Top module: `card_clk_divider`

## Requirements
- R1: A synchronous reset drives `card_clk` low, clears `pending`, selects divide-by-8 and leaves the clock running. After reset the output runs with 4 input cycles high and 4 low.
- R2: Ratio codes on `wdata[1:0]` at address 0 are 00 = divide by 2, 01 = divide by 4 and 10 = divide by 8. For a selected ratio N, `card_clk` is high for N/2 input cycles and low for N/2.
- R3: An accepted setting takes effect only at the end of a complete output period, on the edge where a high phase ends. On that edge `pending` clears. When the old ratio is 8 or less, this happens no more than 9 input cycles after the write.
- R4: A write happens only on a rising edge where `prog_n` and `sel_n` are both low. Port values seen at any other time change neither the settings nor `pending`.
- R5: A ratio code whose output frequency (IN_KHZ divided by the ratio) would exceed OUT_MAX_KHZ is refused. Code 11 is also refused. A refused write leaves the ratio unchanged and `pending` low.
- R6: `pending` is high in the cycle after an accepted write to address 0 or 1.
- R7: Writing address 1 with `wdata[0]`=1 requests a stop, and `wdata[1]` gives the rest level (0 low, 1 high). At the end of the current period the output settles at that level and stays there.
- R8: Writing address 1 with `wdata[0]`=0 while stopped restarts the clock. The first phase is high and lasts a full N/2 input cycles, whatever the rest level was.
- R9: Writes to addresses 2 and 3 are ignored. The ratio is kept and `pending` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| prog_n | input | 1 | Programming enable, active low |
| sel_n | input | 1 | Chip select, active low |
| addr | input | 2 | Programming register address |
| wdata | input | 2 | Programming data |
| card_clk | output | 1 | Divided card clock |
| pending | output | 1 | A written setting awaits its period boundary |

## Verification
The hardest case to reach is a setting that lands at the exact period boundary. This happens when the clock leaves a stopped state at a high rest level: the output must stay high with no visible edge, yet the phase count must restart. The stimulus parks the clock high for many cycles, then issues a run request. It counts high samples from the cycle in which `pending` drops, which shows that the restarted phase is neither merged with the rest period nor cut short. Refused ratios are reached by building the bench with an input frequency at which divide-by-2 breaks the output limit.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;

  localparam int CODE_W = 2;
  localparam logic [CODE_W-1:0] CODE_RESET = 2'd2;   // divide by 8
  localparam logic [CODE_W-1:0] CODE_BAD   = 2'd3;   // never legal

  localparam logic [1:0] REG_RATIO = 2'd0;
  localparam logic [1:0] REG_CTRL  = 2'd1;

  // input cycles per output period
  function automatic int ratio_of(input logic [CODE_W-1:0] code);
    return 2 << code;
  endfunction

  // input cycles per output phase
  function automatic int half_of(input logic [CODE_W-1:0] code);
    return 1 << code;
  endfunction

  // a code is legal when defined and the output stays under the limit
  function automatic logic code_allowed(input logic [CODE_W-1:0] code,
                                        input int in_khz,
                                        input int max_khz);
    if (code == CODE_BAD) return 1'b0;
    return (in_khz / ratio_of(code)) <= max_khz;
  endfunction

endpackage

// File: rtl/ccd_prog_port.sv
module ccd_prog_port
  import card_clk_pkg::*;
#(
  parameter int IN_KHZ      = 40000,
  parameter int OUT_MAX_KHZ = 20000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_n,
  input  logic              sel_n,
  input  logic [1:0]        addr,
  input  logic [1:0]        wdata,
  input  logic              apply,
  output logic              wr_acc,
  output logic [CODE_W-1:0] req_code,
  output logic              req_stop,
  output logic              req_lvl,
  output logic              pend
);

  logic port_en;
  logic hit_ratio;
  logic hit_ctrl;

  assign port_en   = !prog_n && !sel_n;
  assign hit_ratio = port_en && (addr == REG_RATIO) &&
                     code_allowed(wdata, IN_KHZ, OUT_MAX_KHZ);
  assign hit_ctrl  = port_en && (addr == REG_CTRL);
  assign wr_acc    = hit_ratio || hit_ctrl;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_code <= CODE_RESET;
      req_stop <= 1'b0;
      req_lvl  <= 1'b0;
    end else if (hit_ratio) begin
      req_code <= wdata;
    end else if (hit_ctrl) begin
      req_stop <= wdata[0];
      req_lvl  <= wdata[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         pend <= 1'b0;
    else if (wr_acc) pend <= 1'b1;
    else if (apply)  pend <= 1'b0;
  end

endmodule

// File: rtl/ccd_div_core.sv
module ccd_div_core
  import card_clk_pkg::*;
#(
  parameter int MAX_HALF = 4,
  localparam int CNT_W   = $clog2(MAX_HALF) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pend,
  input  logic              wr_acc,
  input  logic [CODE_W-1:0] req_code,
  input  logic              req_stop,
  input  logic              req_lvl,
  output logic              out_clk,
  output logic              running,
  output logic              per_end,
  output logic              apply,
  output logic [CODE_W-1:0] act_code
);

  logic [CNT_W-1:0] cnt_q;
  logic             phase_done;

  assign phase_done = int'(cnt_q) == half_of(act_code) - 1;
  // a stopped clock has no period to finish, so any cycle is a boundary
  assign per_end    = running ? (out_clk && phase_done) : 1'b1;
  // a write in the same cycle wins; its setting waits one more boundary
  assign apply      = per_end && pend && !wr_acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_clk  <= 1'b0;
      cnt_q    <= '0;
      running  <= 1'b1;
      act_code <= CODE_RESET;
    end else if (running) begin
      if (phase_done) begin
        cnt_q <= '0;
        if (apply) begin
          act_code <= req_code;
          if (req_stop) begin
            running <= 1'b0;
            out_clk <= req_lvl;
          end else begin
            out_clk <= 1'b0;
          end
        end else begin
          out_clk <= !out_clk;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (apply) begin
      act_code <= req_code;
      cnt_q    <= '0;
      if (req_stop) begin
        out_clk <= req_lvl;
      end else begin
        running <= 1'b1;
        out_clk <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/card_clk_divider.sv
module card_clk_divider
  import card_clk_pkg::*;
#(
  parameter int IN_KHZ      = 40000,
  parameter int OUT_MAX_KHZ = 20000
) (
  input  logic       clk_in,
  input  logic       rst,
  input  logic       prog_n,
  input  logic       sel_n,
  input  logic [1:0] addr,
  input  logic [1:0] wdata,
  output logic       card_clk,
  output logic       pending
);

  localparam int MAX_HALF = half_of(CODE_RESET);

  logic              wr_acc;
  logic              apply;
  logic              per_end;
  logic              running;
  logic              req_stop;
  logic              req_lvl;
  logic [CODE_W-1:0] req_code;
  logic [CODE_W-1:0] act_code;

  ccd_prog_port #(
    .IN_KHZ      (IN_KHZ),
    .OUT_MAX_KHZ (OUT_MAX_KHZ)
  ) u_port (
    .clk      (clk_in),
    .rst      (rst),
    .prog_n   (prog_n),
    .sel_n    (sel_n),
    .addr     (addr),
    .wdata    (wdata),
    .apply    (apply),
    .wr_acc   (wr_acc),
    .req_code (req_code),
    .req_stop (req_stop),
    .req_lvl  (req_lvl),
    .pend     (pending)
  );

  ccd_div_core #(
    .MAX_HALF (MAX_HALF)
  ) u_core (
    .clk      (clk_in),
    .rst      (rst),
    .pend     (pending),
    .wr_acc   (wr_acc),
    .req_code (req_code),
    .req_stop (req_stop),
    .req_lvl  (req_lvl),
    .out_clk  (card_clk),
    .running  (running),
    .per_end  (per_end),
    .apply    (apply),
    .act_code (act_code)
  );

endmodule

// File: rtl/card_clk_divider_chk.sv
module card_clk_divider_chk
  import card_clk_pkg::*;
#(
  parameter int IN_KHZ      = 40000,
  parameter int OUT_MAX_KHZ = 20000
) (
  input logic              clk_in,
  input logic              rst,
  input logic              prog_n,
  input logic              sel_n,
  input logic              card_clk,
  input logic              pending,
  input logic              wr_acc,
  input logic              apply,
  input logic              per_end,
  input logic              running,
  input logic              req_stop,
  input logic              req_lvl,
  input logic [CODE_W-1:0] req_code,
  input logic [CODE_W-1:0] act_code
);

  AST_GATED_PORT: assert property (@(posedge clk_in) disable iff (rst)
    (prog_n || sel_n) |=> $stable({req_code, req_stop, req_lvl})); // R4

  AST_PEND_AFTER_WRITE: assert property (@(posedge clk_in) disable iff (rst)
    wr_acc |=> pending); // R6

  AST_SWITCH_AT_END: assert property (@(posedge clk_in) disable iff (rst)
    (act_code != $past(act_code)) |-> $past(per_end)); // R3

  AST_PEND_DROPS: assert property (@(posedge clk_in) disable iff (rst)
    apply |=> !pending); // R3

  AST_LEGAL_RATIO: assert property (@(posedge clk_in) disable iff (rst)
    code_allowed(act_code, IN_KHZ, OUT_MAX_KHZ)); // R5

  AST_STOP_HOLD: assert property (@(posedge clk_in) disable iff (rst)
    (!running && !pending) |=> $stable(card_clk)); // R7

endmodule

bind card_clk_divider card_clk_divider_chk #(
  .IN_KHZ      (IN_KHZ),
  .OUT_MAX_KHZ (OUT_MAX_KHZ)
) u_chk (
  .clk_in   (clk_in),
  .rst      (rst),
  .prog_n   (prog_n),
  .sel_n    (sel_n),
  .card_clk (card_clk),
  .pending  (pending),
  .wr_acc   (wr_acc),
  .apply    (apply),
  .per_end  (per_end),
  .running  (running),
  .req_stop (req_stop),
  .req_lvl  (req_lvl),
  .req_code (req_code),
  .act_code (act_code)
);

// File: tb/sim_card_clk_divider.sv
module sim_card_clk_divider;

  logic       clk = 1'b0;
  logic       rst;
  logic       prog_n;
  logic       sel_n;
  logic [1:0] addr;
  logic [1:0] wdata;
  logic       card_clk;
  logic       pending;
  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  // 50 MHz input: divide-by-2 would give 25 MHz, over the 20 MHz limit
  card_clk_divider #(.IN_KHZ(50000), .OUT_MAX_KHZ(20000)) u0 (
    .clk_in(clk), .rst(rst), .prog_n(prog_n), .sel_n(sel_n),
    .addr(addr), .wdata(wdata), .card_clk(card_clk), .pending(pending)
  );

  typedef struct packed {
    logic [1:0] code;
    logic       acc;
    int         half;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 1'b1, 2},
    '{2'd2, 1'b1, 4},
    '{2'd0, 1'b0, 4},
    '{2'd1, 1'b1, 2},
    '{2'd3, 1'b0, 2},
    '{2'd2, 1'b1, 4}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write(input logic [1:0] a, input logic [1:0] d);
    @(negedge clk);
    prog_n = 1'b0; sel_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    prog_n = 1'b1; sel_n = 1'b1;
  endtask

  task automatic wait_applied(output int n, output logic prev);
    n = 0;
    prev = card_clk;
    while (pending && n < 40) begin
      prev = card_clk;
      @(negedge clk);
      n++;
    end
  endtask

  task automatic measure(output int hi, output int lo);
    int g = 0;
    hi = 0; lo = 0;
    while (card_clk !== 1'b0 && g < 100) begin @(negedge clk); g++; end
    while (card_clk !== 1'b1 && g < 200) begin @(negedge clk); g++; end
    while (card_clk === 1'b1 && g < 300) begin hi++; @(negedge clk); g++; end
    while (card_clk === 1'b0 && g < 400) begin lo++; @(negedge clk); g++; end
  endtask

  task automatic count_level(input logic lvl, input int span, output int same);
    same = 0;
    for (int i = 0; i < span; i++) begin
      if (card_clk === lvl) same++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hi, lo, n, same;
    logic prev;
    rst = 1'b1; prog_n = 1'b1; sel_n = 1'b1; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    check(card_clk === 1'b0, "R1 clk low in reset", int'(card_clk), 0);
    check(pending === 1'b0, "R1 pending low in reset", int'(pending), 0);
    rst = 1'b0;
    measure(hi, lo);
    check(hi == 4 && lo == 4, "R1 default divide-by-8", hi * 10 + lo, 44);

    // table walk: ratio writes, accepted and refused
    for (int v = 0; v < NV; v++) begin
      write(2'd0, VECS[v].code);
      check(pending === VECS[v].acc, "R6/R5 pending after ratio write",
            int'(pending), int'(VECS[v].acc));
      if (VECS[v].acc) begin
        wait_applied(n, prev);
        check(n <= 9, "R3 latency bound", n, 9);
        check(prev === 1'b1 && card_clk === 1'b0, "R3 switch on falling boundary",
              int'(prev) * 10 + int'(card_clk), 10);
      end else begin
        repeat (3) @(negedge clk);
        check(pending === 1'b0, "R5 refused code leaves pending low", int'(pending), 0);
      end
      measure(hi, lo);
      check(hi == VECS[v].half && lo == VECS[v].half, "R2 duty and period",
            hi * 10 + lo, VECS[v].half * 11);
    end

    // R4: one qualifier alone must not write
    @(negedge clk);
    prog_n = 1'b0; sel_n = 1'b1; addr = 2'd0; wdata = 2'd1;
    @(negedge clk);
    prog_n = 1'b1; sel_n = 1'b0;
    @(negedge clk);
    prog_n = 1'b1; sel_n = 1'b1;
    check(pending === 1'b0, "R4 ungated write ignored", int'(pending), 0);
    measure(hi, lo);
    check(hi == 4 && lo == 4, "R4 ratio kept", hi * 10 + lo, 44);

    // R9: unused addresses
    write(2'd2, 2'd1);
    check(pending === 1'b0, "R9 addr 2 ignored", int'(pending), 0);
    write(2'd3, 2'd1);
    check(pending === 1'b0, "R9 addr 3 ignored", int'(pending), 0);
    measure(hi, lo);
    check(hi == 4 && lo == 4, "R9 ratio kept", hi * 10 + lo, 44);

    // R7: stop low
    write(2'd1, 2'b01);
    check(pending === 1'b1, "R6 pending after control write", int'(pending), 1);
    wait_applied(n, prev);
    check(n <= 9, "R7 stop latency", n, 9);
    count_level(1'b0, 20, same);
    check(same == 20, "R7 held low", same, 20);

    // R8: run from low, first high phase full
    write(2'd1, 2'b00);
    wait_applied(n, prev);
    count_level(1'b1, 4, same);
    check(same == 4 && card_clk === 1'b0, "R8 full first high phase from low",
          same, 4);

    // R7: stop high
    write(2'd1, 2'b11);
    wait_applied(n, prev);
    count_level(1'b1, 20, same);
    check(same == 20, "R7 held high", same, 20);

    // R8: run from high; phase restarts at the apply edge
    write(2'd1, 2'b10);
    wait_applied(n, prev);
    hi = 0;
    while (card_clk === 1'b1 && hi < 50) begin hi++; @(negedge clk); end
    check(hi == 4, "R8 full first high phase from high", hi, 4);
    measure(hi, lo);
    check(hi == 4 && lo == 4, "R8 steady after resume", hi * 10 + lo, 44);

    // R1: reset in mid-run after a ratio change restores divide-by-8
    write(2'd0, 2'd1);
    wait_applied(n, prev);
    write(2'd0, 2'd2);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(pending === 1'b0 && card_clk === 1'b0, "R1 reset clears pending and clk",
          int'(pending) * 10 + int'(card_clk), 0);
    write(2'd0, 2'd1);
    @(negedge clk);
    rst = 1'b0;
    measure(hi, lo);
    check(hi == 4 && lo == 4, "R1 reset selects divide-by-8", hi * 10 + lo, 44);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule